// File: doc/BRIEF.md
# Forward DCT Row Matrix Stage

This block carries out the horizontal half of an 8x8 forward discrete cosine transform, one row at a time. A row of eight signed 16-bit samples comes in together with a 3-bit row index. The block folds the row into four saturated end-to-end sums and four saturated end-to-end differences. Each of the eight outputs is then a weighted sum of four of those terms, using 16x16 signed products accumulated in 32 bits. The even outputs take the sums and the odd outputs take the differences.

The row index picks the weight set and the rounding offset. Rows that sit symmetrically around the middle of the block share one weight set. Each 32-bit sum keeps only its upper 16 bits. A small offset is then added with saturation, and a final arithmetic shift by four puts the coefficient in a 12-bit range.

Rows enter through a valid/ready handshake and may arrive on every cycle. The eight coefficients leave through a second valid/ready handshake, in the same order the rows went in.

Top module: `fdct_row_stage`

## Requirements
- R1: For i = 0..3 the block forms sum term a_i = x_i + x_(7-i) and difference term b_i = x_i - x_(7-i), each clamped to [-32768, 32767]. Sample i sits in bits [16i+15:16i] of `inSamples`.
- R2: Even output 2m is built from the a terms only, and odd output 2m+1 from the b terms only. Each output is the 32-bit sum, wrapping modulo 2^32, of four signed 16x16 products of weight and term. For a weight set (k4, k2, k6, k1, k3, k5, k7) the weights are:
  - y0 = k4(a0+a1+a2+a3)
  - y2 = k2a0+k6a1-k6a2-k2a3
  - y4 = k4(a0-a1-a2+a3)
  - y6 = k6a0-k2a1+k2a2-k6a3
  - y1 = k1b0+k3b1+k5b2+k7b3
  - y3 = k3b0-k7b1-k1b2-k5b3
  - y5 = k5b0-k1b1+k7b2+k3b3
  - y7 = k7b0-k5b1+k3b2-k1b3
- R3: Rows are mapped to weight sets (k4,k2,k6,k1,k3,k5,k7) in hex as follows:
  - rows 0 and 4: (4000,539f,22a3,58c5,4b42,3249,11a8)
  - rows 1 and 7: (58c5,73fc,300b,7b21,6862,45bf,187e)
  - rows 2 and 6: (539f,6d41,2d41,73fc,6254,41b3,1712)
  - rows 3 and 5: (4b42,6254,28ba,6862,587e,3b21,14c3)
- R4: Each 32-bit sum is arithmetically shifted right by 16, keeping its upper half as a signed 16-bit value.
- R5: A rounding offset is added to that upper half. The offset is 6 for output 0 of rows 0 and 4, 10 for output 0 of row 1, and 8 for every other output of every row.
- R6: The offset addition saturates to 16 bits. The result is then arithmetically shifted right by 4, so every output lies in [-2048, 2047], sign-extended into 16 bits. Output j sits in bits [16j+15:16j] of `outCoefs`.
- R7: With `outReady` held high, a row accepted at one clock edge appears on `outValid`/`outCoefs` three edges later. A new row can be accepted on every cycle.
- R8: While `outValid` is high and `outReady` is low, `outValid` and `outCoefs` hold steady and `inReady` is low. Whenever the output register is empty or is being read, `inReady` is high.
- R9: After reset, `outValid` is low and `inReady` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Row offered on the input side |
| inReady | output | 1 | Block can take a row this cycle |
| inRow | input | 3 | Row index within the 8x8 block |
| inSamples | input | 128 | Eight signed 16-bit samples, sample i in bits [16i+15:16i] |
| outValid | output | 1 | Coefficient row available |
| outReady | input | 1 | Consumer takes the coefficient row |
| outCoefs | output | 128 | Eight signed coefficients, output j in bits [16j+15:16j] |

## Verification
The hardest behaviour to reach from the ports is the saturating offset addition, because it only clips when the upper half of a sum is within a few counts of 32767. The bench reaches it with all-maximum rows, where every sum term clamps at 32767 and the DC output of the first weight set lands exactly on the ceiling. The other weight sets wrap past 2^31 on the same rows, which exercises the modulo accumulation. A sweep of constant rows with small amplitudes across all eight row indices moves the upper half through values where the offsets 6, 8 and 10 round differently. A phase with a randomly stalling consumer checks that held data stays put and that no row is lost or repeated.

// File: rtl/fdct_row_pkg.sv
package fdct_row_pkg;
  localparam int LANES    = 8;
  localparam int HALF     = LANES / 2;
  localparam int SAMPLE_W = 16;
  localparam int ACC_W    = 2 * SAMPLE_W;
  localparam int ROW_W    = $clog2(LANES);
  localparam int SET_W    = 2;
  localparam int NCONST   = 7;
  localparam int OUT_SHIFT = 4;
  localparam int POS_W    = $clog2(LANES);
  localparam int TAP_W    = $clog2(HALF);

  typedef struct packed {
    logic ld1;
    logic ld2;
    logic ld3;
  } stage_strobe_t;

  // weight constants per set, order: k4 k2 k6 k1 k3 k5 k7
  localparam logic [SAMPLE_W-1:0] CONST_TAB [4][NCONST] = '{
    '{16'h4000, 16'h539f, 16'h22a3, 16'h58c5, 16'h4b42, 16'h3249, 16'h11a8},
    '{16'h58c5, 16'h73fc, 16'h300b, 16'h7b21, 16'h6862, 16'h45bf, 16'h187e},
    '{16'h539f, 16'h6d41, 16'h2d41, 16'h73fc, 16'h6254, 16'h41b3, 16'h1712},
    '{16'h4b42, 16'h6254, 16'h28ba, 16'h6862, 16'h587e, 16'h3b21, 16'h14c3}
  };

  // which constant each output position uses on each tap, and its sign
  localparam int PAT_IDX [LANES][HALF] = '{
    '{0, 0, 0, 0}, '{3, 4, 5, 6}, '{1, 2, 2, 1}, '{4, 6, 3, 5},
    '{0, 0, 0, 0}, '{5, 3, 6, 4}, '{2, 1, 1, 2}, '{6, 5, 4, 3}
  };
  localparam bit PAT_NEG [LANES][HALF] = '{
    '{0, 0, 0, 0}, '{0, 0, 0, 0}, '{0, 0, 1, 1}, '{0, 1, 1, 1},
    '{0, 1, 1, 0}, '{0, 1, 0, 0}, '{0, 1, 0, 1}, '{0, 1, 0, 1}
  };

  // rows mirrored about the block centre share a set (R3)
  function automatic logic [SET_W-1:0] rowToSet(input logic [ROW_W-1:0] row);
    case (row)
      3'd0, 3'd4: rowToSet = 2'd0;
      3'd1, 3'd7: rowToSet = 2'd1;
      3'd2, 3'd6: rowToSet = 2'd2;
      default:    rowToSet = 2'd3;
    endcase
  endfunction

  function automatic logic signed [SAMPLE_W-1:0] coefWeight(
      input logic [SET_W-1:0] set, input logic [POS_W-1:0] pos,
      input logic [TAP_W-1:0] tap);
    logic [SAMPLE_W-1:0] base;
    base = CONST_TAB[set][PAT_IDX[pos][tap]];
    coefWeight = PAT_NEG[pos][tap] ? -base : base;
  endfunction

  // R5 offsets
  function automatic logic signed [SAMPLE_W-1:0] rounderOf(
      input logic [ROW_W-1:0] row, input logic [POS_W-1:0] pos);
    if (pos == '0 && (row == 3'd0 || row == 3'd4)) rounderOf = 16'sd6;
    else if (pos == '0 && row == 3'd1)             rounderOf = 16'sd10;
    else                                           rounderOf = 16'sd8;
  endfunction

  function automatic logic signed [SAMPLE_W-1:0] clampWide(
      input logic signed [SAMPLE_W:0] v);
    if (v > 17'sd32767)       clampWide = 16'sh7fff;
    else if (v < -17'sd32768) clampWide = 16'sh8000;
    else                      clampWide = v[SAMPLE_W-1:0];
  endfunction
endpackage

// File: rtl/fdct_row_ctrl.sv
module fdct_row_ctrl
  import fdct_row_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          outReady,
  output logic          inReady,
  output logic          outValid,
  output stage_strobe_t strobe
);
  logic v1, v2, v3;
  logic advance;

  assign advance  = !v3 || outReady;
  assign inReady  = advance;
  assign outValid = v3;

  always_comb begin
    strobe.ld1 = advance && inValid;
    strobe.ld2 = advance && v1;
    strobe.ld3 = advance && v2;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else if (advance) begin
      v1 <= inValid;
      v2 <= v1;
      v3 <= v2;
    end
  end

  // R8: a held output stays offered
  a_r8_hold_valid: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid);

  // R7: an accepted row reaches the first stage
  a_r7_fill: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> v1);
endmodule

// File: rtl/fdct_row_dp.sv
module fdct_row_dp
  import fdct_row_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  stage_strobe_t             strobe,
  input  logic [ROW_W-1:0]          inRow,
  input  logic [LANES*SAMPLE_W-1:0] inSamples,
  output logic [LANES*SAMPLE_W-1:0] outCoefs
);
  logic signed [SAMPLE_W-1:0] xIn  [LANES];
  logic signed [SAMPLE_W-1:0] aReg [HALF];
  logic signed [SAMPLE_W-1:0] bReg [HALF];
  logic [ROW_W-1:0] row1, row2;
  logic [SET_W-1:0] set1;
  logic aZero, bZero, symIn;

  always_comb begin
    for (int i = 0; i < LANES; i++) xIn[i] = inSamples[i*SAMPLE_W +: SAMPLE_W];
  end

  // stage 1: saturating fold (R1)
  always_ff @(posedge clk) begin
    if (strobe.ld1) begin
      row1 <= inRow;
      for (int i = 0; i < HALF; i++) begin
        aReg[i] <= clampWide(SAMPLE_W'(0) + {xIn[i][SAMPLE_W-1], xIn[i]}
                             + {xIn[LANES-1-i][SAMPLE_W-1], xIn[LANES-1-i]});
        bReg[i] <= clampWide({xIn[i][SAMPLE_W-1], xIn[i]}
                             - {xIn[LANES-1-i][SAMPLE_W-1], xIn[LANES-1-i]});
      end
    end
    if (strobe.ld2) row2 <= row1;
  end

  assign set1 = rowToSet(row1);

  always_comb begin
    aZero = 1'b1;
    bZero = 1'b1;
    symIn = 1'b1;
    for (int i = 0; i < HALF; i++) begin
      if (aReg[i] != '0) aZero = 1'b0;
      if (bReg[i] != '0) bZero = 1'b0;
      if (xIn[i] != xIn[LANES-1-i]) symIn = 1'b0;
    end
  end

  for (genvar o = 0; o < LANES; o++) begin : g_lane
    logic signed [ACC_W-1:0]    accNext, accReg;
    logic signed [SAMPLE_W-1:0] hiPart, rnd, rounded, coefReg;

    // stage 2: four products, 32-bit wrapping sum (R2)
    always_comb begin
      logic signed [SAMPLE_W-1:0] wt, tm;
      accNext = '0;
      for (int k = 0; k < HALF; k++) begin
        wt = coefWeight(set1, POS_W'(o), TAP_W'(k));
        tm = (o % 2 == 0) ? aReg[k] : bReg[k];
        accNext = accNext + wt * tm;
      end
    end

    // stage 3: upper half, saturating offset, scale (R4, R5, R6)
    assign hiPart = accReg[ACC_W-1 -: SAMPLE_W];
    assign rnd    = rounderOf(row2, POS_W'(o));
    assign rounded = clampWide({hiPart[SAMPLE_W-1], hiPart} + {rnd[SAMPLE_W-1], rnd});

    always_ff @(posedge clk) begin
      if (strobe.ld2) accReg  <= accNext;
      if (strobe.ld3) coefReg <= rounded >>> OUT_SHIFT;
    end

    assign outCoefs[o*SAMPLE_W +: SAMPLE_W] = coefReg;

    if (o % 2 == 0) begin : g_even
      // R2: even outputs ignore the difference terms
      a_r2_even_from_a: assert property (@(posedge clk) disable iff (!rstN)
        strobe.ld2 && aZero |=> accReg == '0);
    end else begin : g_odd
      // R2: odd outputs ignore the sum terms
      a_r2_odd_from_b: assert property (@(posedge clk) disable iff (!rstN)
        strobe.ld2 && bZero |=> accReg == '0);
    end

    // R6: result range
    a_r6_out_range: assert property (@(posedge clk) disable iff (!rstN)
      strobe.ld3 |=> (coefReg >= -16'sd2048) && (coefReg <= 16'sd2047));
  end

  // R1: mirrored input gives zero difference terms
  a_r1_sym_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ld1 && symIn |=> bZero);
endmodule

// File: rtl/fdct_row_stage.sv
module fdct_row_stage
  import fdct_row_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  output logic                      inReady,
  input  logic [ROW_W-1:0]          inRow,
  input  logic [LANES*SAMPLE_W-1:0] inSamples,
  output logic                      outValid,
  input  logic                      outReady,
  output logic [LANES*SAMPLE_W-1:0] outCoefs
);
  stage_strobe_t strobe;

  fdct_row_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  fdct_row_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inRow     (inRow),
    .inSamples (inSamples),
    .outCoefs  (outCoefs)
  );

  // R8: held coefficients do not change
  a_r8_hold_data: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(outCoefs));
endmodule

// File: tb/test_fdct_row_stage.sv
module test_fdct_row_stage;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [2:0]   inRow = '0;
  logic [127:0] inSamples = '0;
  logic         outValid;
  logic         outReady = 1'b1;
  logic [127:0] outCoefs;

  fdct_row_stage i_fdct_row_stage (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inRow(inRow), .inSamples(inSamples), .outValid(outValid),
    .outReady(outReady), .outCoefs(outCoefs));

  int checks = 0;
  int fails = 0;
  int cycle = 0;
  bit randReady = 0;
  bit timedPhase = 1;
  string phaseTag = "R2";
  bit finished = 0;

  typedef struct {
    logic [127:0] exp;
    int           acc;
    bit           timed;
    string        tag;
  } exp_t;
  exp_t q[$];

  // cosine weights by set: dc, c2, c6, c1, c3, c5, c7
  int W [4][7] = '{
    '{16384, 21407, 8867, 22725, 19266, 12873, 4520},
    '{22725, 29692, 12299, 31521, 26722, 17855, 6270},
    '{21407, 27969, 11585, 29692, 25172, 16819, 5906},
    '{19266, 25172, 10426, 26722, 22654, 15137, 5315}
  };

  function automatic int sat(int v);
    return (v > 32767) ? 32767 : (v < -32768) ? -32768 : v;
  endfunction

  function automatic logic [127:0] refRow(int row, logic [127:0] s);
    int x[8], a[4], b[4], y[8];
    int g, dc, c2, c6, c1, c3, c5, c7, hi, off;
    logic [127:0] res;
    for (int i = 0; i < 8; i++) x[i] = int'($signed(s[16*i +: 16]));
    for (int i = 0; i < 4; i++) begin
      a[i] = sat(x[i] + x[7-i]);
      b[i] = sat(x[i] - x[7-i]);
    end
    g = (row == 0 || row == 4) ? 0 : (row == 1 || row == 7) ? 1 : (row == 2 || row == 6) ? 2 : 3;
    dc = W[g][0]; c2 = W[g][1]; c6 = W[g][2];
    c1 = W[g][3]; c3 = W[g][4]; c5 = W[g][5]; c7 = W[g][6];
    y[0] = dc*a[0] + dc*a[1] + dc*a[2] + dc*a[3];
    y[4] = dc*a[0] - dc*a[1] - dc*a[2] + dc*a[3];
    y[2] = c2*a[0] + c6*a[1] - c6*a[2] - c2*a[3];
    y[6] = c6*a[0] - c2*a[1] + c2*a[2] - c6*a[3];
    y[1] = c1*b[0] + c3*b[1] + c5*b[2] + c7*b[3];
    y[3] = c3*b[0] - c7*b[1] - c1*b[2] - c5*b[3];
    y[5] = c5*b[0] - c1*b[1] + c7*b[2] + c3*b[3];
    y[7] = c7*b[0] - c5*b[1] + c3*b[2] - c1*b[3];
    for (int j = 0; j < 8; j++) begin
      hi = y[j] >>> 16;
      off = 8;
      if (j == 0 && (row == 0 || row == 4)) off = 6;
      if (j == 0 && row == 1) off = 10;
      res[16*j +: 16] = 16'(sat(hi + off) >>> 4);
    end
    return res;
  endfunction

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  logic         prevStall = 0;
  logic [127:0] prevCoefs = '0;

  // monitor: samples mid-cycle, transfers happen on the following edge
  always @(negedge clk) begin
    cycle++;
    if (rstN) begin
      if (prevStall) begin
        checks++;
        if (!(outValid && outCoefs == prevCoefs)) begin
          fails++;
          $display("FAIL R8 held row changed: valid=%0b data=%h expected valid=1 data=%h",
                   outValid, outCoefs, prevCoefs);
        end
      end
      if (outValid && !outReady) begin
        checks++;
        if (inReady) begin
          fails++;
          $display("FAIL R8 inReady=%0b while output held, expected 0", inReady);
        end
      end
      if (outValid && outReady) begin
        checks++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL R7 unexpected output %h, expected none", outCoefs);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (outCoefs !== e.exp) begin
            fails++;
            for (int j = 0; j < 8; j++)
              if (outCoefs[16*j +: 16] !== e.exp[16*j +: 16])
                $display("FAIL %s coef %0d actual %0d expected %0d", e.tag, j,
                         $signed(outCoefs[16*j +: 16]), $signed(e.exp[16*j +: 16]));
          end
          if (e.timed) begin
            checks++;
            if (cycle - e.acc != 3) begin
              fails++;
              $display("FAIL R7 latency actual %0d expected 3", cycle - e.acc);
            end
          end
        end
      end
      if (inValid && inReady) begin
        exp_t n;
        n.exp = refRow(int'(inRow), inSamples);
        n.acc = cycle;
        n.timed = timedPhase;
        n.tag = phaseTag;
        q.push_back(n);
      end
      prevStall = outValid && !outReady;
      prevCoefs = outCoefs;
    end
  end

  always @(posedge clk) begin
    #2;
    outReady = randReady ? ($urandom % 3 != 0) : 1'b1;
  end

  // watchdog
  always @(negedge clk) begin
    if (cycle > 100000 && !finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired at cycle %0d, expected completion", cycle);
      report();
    end
  end

  task automatic sendRow(int row, logic [127:0] s);
    @(posedge clk); #2;
    inValid = 1'b1;
    inRow = 3'(row);
    inSamples = s;
    @(negedge clk);
    while (!inReady) @(negedge clk);
  endtask

  task automatic idle();
    @(posedge clk); #2;
    inValid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && (q.size() != 0 || outValid); i++) @(negedge clk);
  endtask

  function automatic logic [127:0] splat(int v);
    logic [127:0] r;
    for (int i = 0; i < 8; i++) r[16*i +: 16] = 16'(v);
    return r;
  endfunction

  function automatic logic [127:0] rnd128(int mag);
    logic [127:0] r;
    for (int i = 0; i < 8; i++)
      r[16*i +: 16] = (mag == 0) ? 16'($urandom) : 16'(int'($urandom % (2*mag)) - mag);
    return r;
  endfunction

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (outValid !== 1'b0) begin
      fails++;
      $display("FAIL R9 outValid actual %0b expected 0", outValid);
    end
    checks++;
    if (inReady !== 1'b1) begin
      fails++;
      $display("FAIL R9 inReady actual %0b expected 1", inReady);
    end
    @(posedge clk); #2; rstN = 1'b1;

    // R7: single row, then a back-to-back burst
    phaseTag = "R7";
    sendRow(0, rnd128(1000));
    idle(); drain();
    for (int i = 0; i < 8; i++) sendRow(i, rnd128(500));
    idle(); drain();

    // R1, R4, R6: clamping sums, wrapping accumulation, clipped offset
    phaseTag = "R6";
    for (int r = 0; r < 8; r++) begin
      sendRow(r, splat(32767));
      sendRow(r, splat(-32768));
      sendRow(r, {{4{16'h8000}}, {4{16'h7fff}}});
      sendRow(r, {{4{16'h7fff}}, {4{16'h8000}}});
    end
    idle(); drain();
    phaseTag = "R1";
    for (int r = 0; r < 8; r++) sendRow(r, {16'h8000, 16'h7fff, 16'h8001, 16'h7ffe,
                                             16'h1234, 16'h8000, 16'h7fff, 16'h7fff});
    idle(); drain();

    // R3: one pattern through every row index
    phaseTag = "R3";
    begin
      logic [127:0] p;
      p = rnd128(0);
      for (int r = 0; r < 8; r++) sendRow(r, p);
      p = rnd128(3000);
      for (int r = 7; r >= 0; r--) sendRow(r, p);
    end
    idle(); drain();

    // R5: small constant rows to hit offset rounding boundaries
    phaseTag = "R5";
    for (int v = -24; v <= 24; v += 3)
      for (int r = 0; r < 8; r++) sendRow(r, splat(v));
    for (int i = 0; i < 40; i++) sendRow(i % 8, rnd128(40));
    idle(); drain();

    // R2: general random rows, full range and mid range
    phaseTag = "R2";
    for (int i = 0; i < 120; i++) sendRow($urandom % 8, (i % 2) ? rnd128(0) : rnd128(8000));
    idle(); drain();

    // R8: consumer stalls at random, producer has gaps
    phaseTag = "R8";
    timedPhase = 0;
    randReady = 1;
    for (int i = 0; i < 150; i++) begin
      sendRow($urandom % 8, rnd128(0));
      if ($urandom % 4 == 0) idle();
    end
    idle();
    randReady = 0;
    drain();

    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R8 rows missing at end: actual %0d pending expected 0", q.size());
    end
    report();
  end
endmodule